// File: doc/BRIEF.md
# Egress Source-MAC Group-Bit Marker

This block sits on a transmit datapath and rewrites a single bit of each outgoing Ethernet frame: the group (multicast) bit of the source MAC address. A receiving device that splits its traffic between two forwarding engines can read that bit to choose an engine. The bit is either forced to zero, taken from the index of the local engine that sent the frame, or derived from a one-bit hash of the frame header. The hash keeps all frames of one flow on the same side while spreading flows over both sides.

Frames arrive as a stream of beats of `BEAT_BYTES` bytes, with start and end markers and a one-bit engine index beside the data. `BEAT_BYTES` must be at least 14, so the destination MAC, source MAC and EtherType all sit in the first beat. The output stream is the input stream delayed by one register stage. Only the one bit is changed. A flag on the last beat tells the downstream FCS generator that the checksum must be rebuilt because the bit was altered. The block does not recompute the FCS itself.

Top module: `sa_group_marker`

## Requirements
- R1: Output valid, start and end markers equal the input markers delayed by exactly one clock. An idle input cycle gives an idle output cycle.
- R2: Byte k of a beat is carried on data bits 8k+7..8k. The group bit is data bit 48 (byte 6, bit 0) of the first beat. Every other bit of the first beat, and every bit of later beats, leaves the block unchanged.
- R3: Mode code 2'b00 (off) and the reserved code 2'b11 both write 0 into the group bit.
- R4: Mode code 2'b01 (engine) writes the engine index present on the first beat into the group bit.
- R5: Mode code 2'b10 (flow) writes the XOR of all bits of header bytes 0 to 13, with data bit 48 excluded.
- R6: In flow mode, the incoming value of the group bit does not change the bit written. Two copies of a frame that differ only in that bit get the same mark.
- R7: Mode and engine index are sampled only on the first beat of a frame. Values on later beats have no effect on that frame's mark or end flag.
- R8: The FCS-rebuild flag is high on the output end beat only when the written group bit differs from the incoming one. It is low on every other beat.
- R9: A frame of one beat (start and end together) gets its mark and its FCS-rebuild flag on the same output beat.
- R10: During reset, output valid, start, end and FCS-rebuild flag are all low.
- R11: Idle cycles inside a frame do not lose the record of whether the bit was altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_sof | input | 1 | Input beat is the first of a frame |
| in_eof | input | 1 | Input beat is the last of a frame |
| in_data | input | BEAT_BYTES*8 | Input beat, byte 0 in the low bits |
| in_eng | input | 1 | Index of the sending engine (0 or 1) |
| in_mode | input | 2 | Marking mode: 00 off, 01 engine, 10 flow, 11 off |
| out_valid | output | 1 | Output beat present |
| out_sof | output | 1 | Output beat is the first of a frame |
| out_eof | output | 1 | Output beat is the last of a frame |
| out_data | output | BEAT_BYTES*8 | Output beat with the group bit rewritten |
| out_fcs_redo | output | 1 | On the end beat: FCS must be regenerated |

## Verification
Two functions can land on the same output beat: the group-bit rewrite done on a first beat, and the FCS-rebuild decision made on a last beat. They coincide when a frame is only one beat long. The bench sends such frames in engine mode twice: once with an incoming bit that must be flipped, and once with a bit that already matches. In the same output cycle it checks both the rewritten data bit and the presence or absence of the flag. It also runs multi-beat frames with idle gaps between beats. Those confirm that the flag still follows the first-beat decision when the two events are far apart.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

  localparam int HDR_BYTES = 14;
  localparam int GRP_BYTE  = 6;
  localparam int GRP_BIT   = 0;
  localparam int GRP_POS   = GRP_BYTE * 8 + GRP_BIT;

  typedef enum logic [1:0] {
    MARK_OFF    = 2'b00,
    MARK_ENGINE = 2'b01,
    MARK_FLOW   = 2'b10,
    MARK_RSVD   = 2'b11
  } mark_mode_e;

  // Chooses the value written into the group bit.
  function automatic logic pick_mark(mark_mode_e m, logic eng, logic flow_bit);
    case (m)
      MARK_ENGINE: return eng;
      MARK_FLOW:   return flow_bit;
      default:     return 1'b0;
    endcase
  endfunction

  // Parity of one header byte with an optional bit excluded.
  function automatic logic lane_parity(logic [7:0] b, logic drop_grp);
    logic [7:0] keep;
    keep = drop_grp ? ~(8'(1) << GRP_BIT) : 8'hFF;
    return ^(b & keep);
  endfunction

  // Replaces the group bit inside one byte.
  function automatic logic [7:0] put_grp(logic [7:0] b, logic v);
    logic [7:0] m;
    m = 8'(1) << GRP_BIT;
    return (b & ~m) | (v ? m : 8'h00);
  endfunction

endpackage

// File: rtl/sgm_flow_hash.sv
module sgm_flow_hash
  import sgm_pkg::*;
#(
  parameter int BEAT_BYTES = 16
) (
  input  logic [BEAT_BYTES*8-1:0] beat,
  output logic                    flow_bit
);

  localparam int DATA_W = BEAT_BYTES * 8;

  logic [HDR_BYTES-1:0] lane_par;

  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_lane
    localparam logic DROP = (i == GRP_BYTE);
    assign lane_par[i] = lane_parity(beat[8*i +: 8], DROP);
  end

  assign flow_bit = ^lane_par;

  logic unused_tail;
  assign unused_tail = ^beat[DATA_W-1:HDR_BYTES*8];

endmodule

// File: rtl/sgm_bit_select.sv
module sgm_bit_select
  import sgm_pkg::*;
(
  input  logic       sof_beat,
  input  logic [1:0] mode,
  input  logic       eng,
  input  logic       flow_bit,
  input  logic       cur_bit,
  output logic       new_bit,
  output logic       flip
);

  mark_mode_e mode_e;

  assign mode_e  = mark_mode_e'(mode);
  assign new_bit = pick_mark(mode_e, eng, flow_bit);
  assign flip    = sof_beat & (new_bit != cur_bit);

endmodule

// File: rtl/sgm_out_stage.sv
module sgm_out_stage
  import sgm_pkg::*;
#(
  parameter int BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [BEAT_BYTES*8-1:0] in_data,
  input  logic                    sof_beat,
  input  logic                    new_bit,
  input  logic                    flip,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic                    out_eof,
  output logic [BEAT_BYTES*8-1:0] out_data,
  output logic                    out_fcs_redo
);

  localparam int DATA_W = BEAT_BYTES * 8;

  logic [DATA_W-1:0] next_data;
  logic              flip_q;
  logic              regen;

  for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_byte
    if (i == GRP_BYTE) begin : g_grp
      assign next_data[8*i +: 8] = sof_beat ? put_grp(in_data[8*i +: 8], new_bit)
                                            : in_data[8*i +: 8];
    end else begin : g_pass
      assign next_data[8*i +: 8] = in_data[8*i +: 8];
    end
  end

  assign regen = in_valid & in_eof & (sof_beat ? flip : flip_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flip_q       <= 1'b0;
      out_valid    <= 1'b0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      out_fcs_redo <= 1'b0;
      out_data     <= '0;
    end else begin
      if (sof_beat) flip_q <= flip;
      out_valid    <= in_valid;
      out_sof      <= in_valid & in_sof;
      out_eof      <= in_valid & in_eof;
      out_fcs_redo <= regen;
      if (in_valid) out_data <= next_data;
    end
  end

endmodule

// File: rtl/sa_group_marker.sv
module sa_group_marker
  import sgm_pkg::*;
#(
  parameter int BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [BEAT_BYTES*8-1:0] in_data,
  input  logic                    in_eng,
  input  logic [1:0]              in_mode,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic                    out_eof,
  output logic [BEAT_BYTES*8-1:0] out_data,
  output logic                    out_fcs_redo
);

  localparam int DATA_W = BEAT_BYTES * 8;

  // Named internal events, also watched by the checker.
  logic sof_beat;
  logic flow_bit;
  logic mark_bit;
  logic mark_flip;

  assign sof_beat = in_valid & in_sof;

  sgm_flow_hash #(.BEAT_BYTES(BEAT_BYTES)) u_hash (
    .beat     (in_data),
    .flow_bit (flow_bit)
  );

  sgm_bit_select u_sel (
    .sof_beat (sof_beat),
    .mode     (in_mode),
    .eng      (in_eng),
    .flow_bit (flow_bit),
    .cur_bit  (in_data[GRP_POS]),
    .new_bit  (mark_bit),
    .flip     (mark_flip)
  );

  sgm_out_stage #(.BEAT_BYTES(BEAT_BYTES)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .in_data      (in_data),
    .sof_beat     (sof_beat),
    .new_bit      (mark_bit),
    .flip         (mark_flip),
    .out_valid    (out_valid),
    .out_sof      (out_sof),
    .out_eof      (out_eof),
    .out_data     (out_data),
    .out_fcs_redo (out_fcs_redo)
  );

endmodule

// File: rtl/sgm_checker.sv
module sgm_checker
  import sgm_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [DATA_W-1:0] in_data,
  input logic              in_eng,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_eof,
  input logic [DATA_W-1:0] out_data,
  input logic              out_fcs_redo,
  input logic              mark_flip
);

  localparam logic [DATA_W-1:0] GMASK = DATA_W'(1) << GRP_POS;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_later_beats_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sof |=> out_data == $past(in_data));

  a_r2_first_beat_rest: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |=> (out_data & ~GMASK) == ($past(in_data) & ~GMASK));

  a_r3_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && (in_mode == 2'b00 || in_mode == 2'b11)
    |=> out_data[GRP_POS] == 1'b0);

  a_r4_engine_copy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && in_mode == 2'b01 |=> out_data[GRP_POS] == $past(in_eng));

  a_r8_flag_on_eof_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_fcs_redo |-> out_valid && out_eof);

  a_r9_single_beat_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && in_eof |=> out_fcs_redo == $past(mark_flip));

endmodule

bind sa_group_marker sgm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_sof       (in_sof),
  .in_eof       (in_eof),
  .in_data      (in_data),
  .in_eng       (in_eng),
  .in_mode      (in_mode),
  .out_valid    (out_valid),
  .out_eof      (out_eof),
  .out_data     (out_data),
  .out_fcs_redo (out_fcs_redo),
  .mark_flip    (mark_flip)
);

// File: tb/sa_group_marker_tb.sv
module sa_group_marker_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_eng = 1'b0;
  logic [127:0] in_data = '0;
  logic [1:0]   in_mode = 2'b00;
  logic         out_valid, out_sof, out_eof, out_fcs_redo;
  logic [127:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sa_group_marker #(.BEAT_BYTES(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_eng(in_eng), .in_mode(in_mode),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data), .out_fcs_redo(out_fcs_redo)
  );

  // {mode[1:0], engine, incoming group bit, seed[31:0]}
  localparam logic [35:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 32'h1234_5678},
    {2'd0, 1'b1, 1'b1, 32'hCAFE_0001},
    {2'd1, 1'b0, 1'b1, 32'h0BAD_F00D},
    {2'd1, 1'b1, 1'b0, 32'h5555_AAAA},
    {2'd2, 1'b0, 1'b0, 32'hDEAD_BEEF},
    {2'd2, 1'b1, 1'b1, 32'h0F0F_3C3C},
    {2'd3, 1'b1, 1'b1, 32'h7777_1111},
    {2'd2, 1'b0, 1'b1, 32'h8000_0001}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_beat(logic [31:0] seed, int idx);
    logic [127:0] r;
    for (int j = 0; j < 4; j++)
      r[32*j +: 32] = seed ^ (32'h9E37_79B9 * 32'(idx * 4 + j + 1)) ^ (seed << j);
    return r;
  endfunction

  // Parity by counting ones over bytes 0..13, skipping bit 48.
  function automatic logic ref_flow(logic [127:0] b);
    int ones = 0;
    for (int k = 0; k < 112; k++)
      if (k != 48 && b[k]) ones++;
    return ones[0];
  endfunction

  function automatic logic ref_mark(logic [1:0] m, logic e, logic [127:0] b);
    if (m == 2'b01) return e;
    if (m == 2'b10) return ref_flow(b);
    return 1'b0;
  endfunction

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    @(posedge clk); #1;
    check("R1 idle valid", 128'(out_valid), 128'(0));
    check("R8 idle flag", 128'(out_fcs_redo), 128'(0));
  endtask

  // Sends a frame and checks every output beat. Later beats drive
  // inverted mode and engine (R7). gap inserts idle cycles (R11).
  task automatic run_frame(input logic [1:0] m, input logic e, input logic g,
                           input logic [31:0] seed, input int nbeats, input int gap,
                           input string tag, output logic mark_seen);
    logic [127:0] d, exp_d;
    logic         exp_bit;
    mark_seen = 1'b0;
    exp_bit = 1'b0;
    for (int i = 0; i < nbeats; i++) begin
      if (i == 1) for (int k = 0; k < gap; k++) idle_cycle();
      d = mk_beat(seed, i);
      if (i == 0) begin
        d[48] = g;
        exp_bit = ref_mark(m, e, d);
      end
      exp_d = d;
      if (i == 0) exp_d[48] = exp_bit;
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == nbeats - 1);
      in_data  = d;
      in_mode  = (i == 0) ? m : ~m;
      in_eng   = (i == 0) ? e : ~e;
      @(posedge clk); #1;
      check({tag, " R1 valid"}, 128'(out_valid), 128'(1));
      check({tag, " R1 sof"}, 128'(out_sof), 128'(i == 0));
      check({tag, " R1 eof"}, 128'(out_eof), 128'(i == nbeats - 1));
      check({tag, " R2 R3 R4 R5 data"}, out_data, exp_d);
      check({tag, " R8 flag"}, 128'(out_fcs_redo),
            128'((i == nbeats - 1) && (exp_bit != g)));
      if (i == 0) mark_seen = out_data[48];
    end
    idle_cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic mk0, mk1;
    // R10: outputs stay low while reset is held, even with input active
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = '1; in_mode = 2'b01; in_eng = 1'b1;
    @(posedge clk); #1;
    check("R10 valid", 128'(out_valid), 128'(0));
    check("R10 sof eof", {126'(0), out_sof, out_eof}, 128'(0));
    check("R10 flag", 128'(out_fcs_redo), 128'(0));
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    rst_n = 1'b1;
    idle_cycle();

    // Table of modes, engine values and incoming bits (R3 R4 R5)
    for (int v = 0; v < 8; v++)
      run_frame(VEC[v][35:34], VEC[v][33], VEC[v][32], VEC[v][31:0], 3, 0, "table", mk0);

    // R6: same header, incoming bit 0 then 1, flow mode
    run_frame(2'b10, 1'b0, 1'b0, 32'h3141_5926, 2, 0, "R6 copy0", mk0);
    run_frame(2'b10, 1'b0, 1'b1, 32'h3141_5926, 2, 0, "R6 copy1", mk1);
    check("R6 same mark", 128'(mk1), 128'(mk0));

    // R7: later beats carry different mode/engine; flag follows first beat
    run_frame(2'b01, 1'b1, 1'b0, 32'h2718_2818, 4, 0, "R7 engine", mk0);
    run_frame(2'b00, 1'b0, 1'b0, 32'h1618_0339, 4, 0, "R7 off", mk0);

    // R9: one-beat frames, flip and no flip
    run_frame(2'b01, 1'b1, 1'b0, 32'hABCD_0123, 1, 0, "R9 flip", mk0);
    run_frame(2'b01, 1'b1, 1'b1, 32'hABCD_0456, 1, 0, "R9 keep", mk0);

    // R11: idle gaps between first and later beats
    run_frame(2'b01, 1'b0, 1'b1, 32'h0FED_CBA9, 3, 2, "R11 gap flip", mk0);
    run_frame(2'b10, 1'b1, 1'b0, 32'h600D_CAFE, 3, 3, "R11 gap flow", mk0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule